// File: doc/BRIEF.md
# Banked Program Counter Sequencer

This block works out the instruction fetch address of a small RISC controller, one command per instruction cycle. The fetch address is 16 bits wide. The upper three bits are a bank field, supplied each cycle from a bank register held outside the block. The lower thirteen bits are the program counter, kept inside the block. Every cycle the decoder issues a next-address command. The sequencer then steps the counter, skips, patches the low byte, jumps, calls, returns, enters a timer vector or clears itself.

An eight-entry return-address stack holds the address to resume at after a call or a timer entry. Its full and empty states appear on two outputs. Whenever the counter leaves sequential flow, a one-cycle dummy flag tells the pipeline to discard the instruction it has already fetched.

Top module: `pcseq_top`

## Requirements
- R1: A synchronous active-high `rst`, or command code 8 (clear), sets the fetch address to 0x0000 in the next cycle, including the bank field. `rst` also empties the stack and clears the dummy flag. Command 8 clears the dummy flag and leaves the stack as it is.
- R2: The fetch address is {bank, pc}, with the bank in bits 15..13 and the counter in bits 12..0. For every command other than clear, the bank field is taken from `bank_i` as sampled at that edge. Command code 0 (step), and every unused code from 9 to 15, loads pc+1 modulo 8192.
- R3: Command code 1 (skip) loads pc+2 modulo 8192.
- R4: Command code 2 (low-byte write) replaces pc bits 7..0 with `pcl_i` and keeps bits 12..8.
- R5: Command code 3 (jump) loads all 13 counter bits from `imm_i`.
- R6: Command code 4 (call) pushes pc+1 and loads `imm_i`. If the stack is full, the push is dropped and the jump still happens.
- R7: Command code 5 (return) pops the top entry into the counter. On an empty stack it loads 0 and the stack stays empty.
- R8: Command code 6 enters vector 0x008 and command code 7 enters vector 0x00C, each pushing pc+1. With the stack full, the entry is not taken and the command behaves as a step.
- R9: `dummy_o` is high for exactly the one cycle that follows a taken skip, low-byte write, jump, call, return or timer entry. It is low after a step or a clear.
- R10: The stack holds eight entries. `stk_full_o` is high with eight entries stored and `stk_empty_o` is high with none. Entries come back last-in first-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 4 | Next-address command code |
| imm_i | input | 13 | Target taken from the instruction |
| pcl_i | input | 8 | Value for a low-byte write |
| bank_i | input | 3 | Current bank register value |
| fetch_addr_o | output | 16 | Registered fetch address {bank, pc} |
| dummy_o | output | 1 | Discard the fetched instruction this cycle |
| stk_full_o | output | 1 | Return stack holds eight entries |
| stk_empty_o | output | 1 | Return stack holds no entries |

## Verification
The hardest case to reach is the full stack. It takes eight calls in a row, each with a distinct target, before any overflow behaviour can be seen. The stimulus makes those eight calls, then issues a ninth call and a timer 0 entry while the stack is full. The ninth call must jump without a push, and the timer entry must fall through as a plain step. The bench then unwinds all eight entries and checks each returned address against the order it recorded on the way in. This exposes a lost or overwritten entry.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int PC_W     = 13;
    localparam int BANK_W   = 3;
    localparam int LOW_W    = 8;
    localparam int RS_DEPTH = 8;
    localparam int ADDR_W   = PC_W + BANK_W;

    typedef enum logic [3:0] {
        CMD_STEP  = 4'd0,
        CMD_SKIP  = 4'd1,
        CMD_LOWWR = 4'd2,
        CMD_JUMP  = 4'd3,
        CMD_CALL  = 4'd4,
        CMD_RET   = 4'd5,
        CMD_TMR0  = 4'd6,
        CMD_TMR1  = 4'd7,
        CMD_CLEAR = 4'd8
    } seq_cmd_e;

    // control decisions taken alongside the next counter value
    typedef struct packed {
        logic push;
        logic pop;
        logic xfer;
        logic zero_bank;
    } seq_ctl_t;

    localparam logic [PC_W-1:0] TMR0_VEC = 13'h008;
    localparam logic [PC_W-1:0] TMR1_VEC = 13'h00C;

    // keep the upper counter bits, replace the low byte
    function automatic logic [PC_W-1:0] patch_low(input logic [PC_W-1:0] pc,
                                                  input logic [LOW_W-1:0] lo);
        return {pc[PC_W-1:LOW_W], lo};
    endfunction

endpackage

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     ent_q [DEPTH];
    logic             do_push;
    logic             do_pop;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty && !push;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            always_ff @(posedge clk) begin
                if (do_push && cnt_q == CNT_W'(i))
                    ent_q[i] <= din;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (do_push)
            cnt_q <= cnt_q + CNT_W'(1);
        else if (do_pop)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++)
            if (cnt_q == CNT_W'(i + 1))
                top = ent_q[i];
    end

    // R10
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

    // R6
    full_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> (cnt_q == $past(cnt_q)));

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && empty) |=> empty);

endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
    import pcseq_pkg::*;
#(
    parameter int               NPC_W = 13,
    parameter logic [NPC_W-1:0] VEC0  = 13'h008,
    parameter logic [NPC_W-1:0] VEC1  = 13'h00C
) (
    input  logic [3:0]       cmd,
    input  logic [NPC_W-1:0] pc,
    input  logic [NPC_W-1:0] imm,
    input  logic [LOW_W-1:0] low,
    input  logic [NPC_W-1:0] stk_top,
    input  logic             stk_full,
    output logic [NPC_W-1:0] pc_nxt,
    output logic [NPC_W-1:0] ret_addr,
    output seq_ctl_t         ctl
);
    logic [NPC_W-1:0] pc_inc;

    assign pc_inc   = pc + NPC_W'(1);
    assign ret_addr = pc_inc;

    always_comb begin
        pc_nxt = pc_inc;
        ctl    = '0;
        case (seq_cmd_e'(cmd))
            CMD_SKIP: begin
                pc_nxt   = pc + NPC_W'(2);
                ctl.xfer = 1'b1;
            end
            CMD_LOWWR: begin
                pc_nxt   = {pc[NPC_W-1:LOW_W], low};
                ctl.xfer = 1'b1;
            end
            CMD_JUMP: begin
                pc_nxt   = imm;
                ctl.xfer = 1'b1;
            end
            CMD_CALL: begin
                pc_nxt   = imm;
                ctl.push = 1'b1;
                ctl.xfer = 1'b1;
            end
            CMD_RET: begin
                pc_nxt   = stk_top;
                ctl.pop  = 1'b1;
                ctl.xfer = 1'b1;
            end
            CMD_TMR0, CMD_TMR1: begin
                if (!stk_full) begin
                    pc_nxt   = (seq_cmd_e'(cmd) == CMD_TMR0) ? VEC0 : VEC1;
                    ctl.push = 1'b1;
                    ctl.xfer = 1'b1;
                end
            end
            CMD_CLEAR: begin
                pc_nxt        = '0;
                ctl.zero_bank = 1'b1;
            end
            default: pc_nxt = pc_inc;
        endcase
    end

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int PCW   = PC_W,
    parameter int BW    = BANK_W,
    parameter int DEPTH = RS_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        cmd_i,
    input  logic [PCW-1:0]    imm_i,
    input  logic [LOW_W-1:0]  pcl_i,
    input  logic [BW-1:0]     bank_i,
    output logic [PCW+BW-1:0] fetch_addr_o,
    output logic              dummy_o,
    output logic              stk_full_o,
    output logic              stk_empty_o
);
    logic [PCW-1:0] pc_q;
    logic [BW-1:0]  bank_q;
    logic           dummy_q;
    logic [PCW-1:0] pc_nxt;
    logic [PCW-1:0] ret_addr;
    logic [PCW-1:0] stk_top;
    logic           stk_full;
    logic           stk_empty;
    seq_ctl_t       ctl;

    pcseq_next #(
        .NPC_W (PCW),
        .VEC0  (PCW'(TMR0_VEC)),
        .VEC1  (PCW'(TMR1_VEC))
    ) u_next (
        .cmd      (cmd_i),
        .pc       (pc_q),
        .imm      (imm_i),
        .low      (pcl_i),
        .stk_top  (stk_top),
        .stk_full (stk_full),
        .pc_nxt   (pc_nxt),
        .ret_addr (ret_addr),
        .ctl      (ctl)
    );

    pcseq_stack #(
        .W     (PCW),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (ctl.push),
        .pop   (ctl.pop),
        .din   (ret_addr),
        .top   (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            bank_q  <= '0;
            dummy_q <= 1'b0;
        end else begin
            pc_q    <= pc_nxt;
            bank_q  <= ctl.zero_bank ? '0 : bank_i;
            dummy_q <= ctl.xfer;
        end
    end

    assign fetch_addr_o = {bank_q, pc_q};
    assign dummy_o      = dummy_q;
    assign stk_full_o   = stk_full;
    assign stk_empty_o  = stk_empty;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (fetch_addr_o == '0 && !dummy_o && stk_empty_o));

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 4'(CMD_STEP)) |=> (pc_q == $past(pc_q) + PCW'(1)));

    // R5
    jump_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 4'(CMD_JUMP)) |=> (pc_q == $past(imm_i)));

    // R9
    jump_dummy_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 4'(CMD_JUMP)) |=> dummy_o);

    // R9
    step_nodummy_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 4'(CMD_STEP)) |=> !dummy_o);

    // R10
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(stk_full_o && stk_empty_o));

endmodule

// File: tb/pcseq_top_tb.sv
module pcseq_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cmd = 4'd0;
    logic [12:0] imm = '0;
    logic [7:0]  pcl = '0;
    logic [2:0]  bank = '0;
    logic [15:0] addr;
    logic        dummy, full, empty;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pcseq_top u_dut (
        .clk          (clk),
        .rst          (rst),
        .cmd_i        (cmd),
        .imm_i        (imm),
        .pcl_i        (pcl),
        .bank_i       (bank),
        .fetch_addr_o (addr),
        .dummy_o      (dummy),
        .stk_full_o   (full),
        .stk_empty_o  (empty)
    );

    // fields: cmd, imm, pcl, bank, expected addr, dummy, full, empty, requirement
    localparam int NV = 17;
    localparam logic [50:0] VEC [NV] = '{
        {4'd0, 13'h0000, 8'h00, 3'd0, 16'h0001, 1'b0, 1'b0, 1'b1, 4'd2},  // R2
        {4'd0, 13'h0000, 8'h00, 3'd5, 16'hA002, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 bank
        {4'd1, 13'h0000, 8'h00, 3'd5, 16'hA004, 1'b1, 1'b0, 1'b1, 4'd3},  // R3
        {4'd3, 13'h1234, 8'h00, 3'd5, 16'hB234, 1'b1, 1'b0, 1'b1, 4'd5},  // R5
        {4'd2, 13'h0000, 8'h56, 3'd5, 16'hB256, 1'b1, 1'b0, 1'b1, 4'd4},  // R4
        {4'd4, 13'h0100, 8'h00, 3'd5, 16'hA100, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
        {4'd6, 13'h0000, 8'h00, 3'd5, 16'hA008, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
        {4'd7, 13'h0000, 8'h00, 3'd2, 16'h400C, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
        {4'd0, 13'h0000, 8'h00, 3'd2, 16'h400D, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
        {4'd5, 13'h0000, 8'h00, 3'd2, 16'h4009, 1'b1, 1'b0, 1'b0, 4'd7},  // R7
        {4'd5, 13'h0000, 8'h00, 3'd2, 16'h4101, 1'b1, 1'b0, 1'b0, 4'd7},  // R7
        {4'd5, 13'h0000, 8'h00, 3'd2, 16'h5257, 1'b1, 1'b0, 1'b1, 4'd10}, // R10
        {4'd5, 13'h0000, 8'h00, 3'd2, 16'h4000, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 empty
        {4'd3, 13'h1FFF, 8'h00, 3'd0, 16'h1FFF, 1'b1, 1'b0, 1'b1, 4'd5},  // R5
        {4'd0, 13'h0000, 8'h00, 3'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 wrap
        {4'd12,13'h0000, 8'h00, 3'd1, 16'h2001, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 unused code
        {4'd8, 13'h0000, 8'h00, 3'd7, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd1}   // R1 clear
    };

    task automatic check(input string req, input logic [18:0] got, input logic [18:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got addr=%h d=%b f=%b e=%b, expected addr=%h d=%b f=%b e=%b",
                     req, got[18:3], got[2], got[1], got[0],
                     exp[18:3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic apply(input logic [3:0] c, input logic [12:0] im,
                         input logic [7:0] lo, input logic [2:0] bk);
        cmd  = c;
        imm  = im;
        pcl  = lo;
        bank = bk;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [18:0] obs();
        return {addr, dummy, full, empty};
    endfunction

    initial begin
        logic [12:0] exp_ret [8];
        logic [12:0] pc_m;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", obs(), {16'h0000, 1'b0, 1'b0, 1'b1});

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][50:47], VEC[i][46:34], VEC[i][33:26], VEC[i][25:23]);
            check($sformatf("R%0d vec%0d", VEC[i][3:0], i), obs(), VEC[i][22:4]);
        end

        // R10 fill the stack with eight calls
        pc_m = '0;
        for (int i = 0; i < 8; i++) begin
            exp_ret[i] = pc_m + 13'd1;
            pc_m = 13'h010 + 13'(i);
            apply(4'd4, pc_m, 8'h00, 3'd0);
        end
        check("R10 full", obs(), {16'h0017, 1'b1, 1'b1, 1'b0});

        // R6 call with a full stack still jumps, push dropped
        apply(4'd4, 13'h0050, 8'h00, 3'd0);
        check("R6 full call", obs(), {16'h0050, 1'b1, 1'b1, 1'b0});

        // R8 timer entry refused when full: acts as a step, no dummy
        apply(4'd6, 13'h0000, 8'h00, 3'd0);
        check("R8 refused", obs(), {16'h0051, 1'b0, 1'b1, 1'b0});

        // R10 unwind in last-in first-out order
        for (int k = 7; k >= 0; k--) begin
            apply(4'd5, 13'h0000, 8'h00, 3'd0);
            check($sformatf("R10 pop%0d", k), obs(),
                  {3'd0, exp_ret[k], 1'b1, 1'b0, (k == 0)});
        end

        // R1 reset input clears a non-empty stack
        apply(4'd4, 13'h0AAA, 8'h00, 3'd3);
        check("R6 push", obs(), {16'h6AAA, 1'b1, 1'b0, 1'b0});
        rst = 1'b1;
        apply(4'd0, 13'h0000, 8'h00, 3'd3);
        rst = 1'b0;
        check("R1 rst", obs(), {16'h0000, 1'b0, 1'b0, 1'b1});

        // R4 low-byte write keeps the upper counter bits
        apply(4'd3, 13'h1E80, 8'h00, 3'd0);
        apply(4'd2, 13'h0000, 8'hFF, 3'd0);
        check("R4 high keep", obs(), {16'h1EFF, 1'b1, 1'b0, 1'b1});

        // R3 skip wraps within the bank
        apply(4'd3, 13'h1FFF, 8'h00, 3'd4);
        apply(4'd1, 13'h0000, 8'h00, 3'd4);
        check("R3 wrap", obs(), {16'h8001, 1'b1, 1'b0, 1'b1});

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule